// File: doc/BRIEF.md
# Watchdog and Reset Sequencer

This block is the reset source for a small 8-bit microcontroller. It merges three causes of reset into one active-high reset output: a power-up hold timer, a watchdog that fires when software stops servicing it, and an external reset request. The reset output stays asserted for as long as any one of those sources is active, so a long external request stretches a power-up hold or a watchdog pulse.

The watchdog counts while its option bit is set and no high-voltage programming mode is flagged. Software keeps it quiet by writing a byte with bit 0 clear to one fixed bus address. A read from that same address returns a constant vector byte and leaves the watchdog untouched. When the counter rolls past its last value, a reset pulse of fixed length is issued, and counting starts again from zero once reset releases.

The active-low power indication resets every register in the block at once. The external request is brought into the clock domain before it is used.

Top module: `wdt_rst_seq`

## Requirements
- R1: After `powerOnN` rises, `rstOut` stays high for exactly `PorCycles` rising clock edges (default 4064), then falls if no other source is active.
- R2: With the watchdog running and never cleared, a timeout occurs on the 2^`WdtBits`-th running edge (default 2^18) after the last clear or restart, and this raises `rstOut` right after that edge.
- R3: A timeout keeps `rstOut` high for exactly `PulseLen` edges (default 16), and the counter restarts from zero.
- R4: A write (`wrEn`=1) to address `ClearAddr` (default 0x1FF0) with `wrData` bit 0 equal to 0 sets the counter to zero. When it falls on the same edge as a timeout, the clear wins and no pulse starts.
- R5: A write to `ClearAddr` with bit 0 equal to 1, or a write to any other address, does not change the watchdog timing.
- R6: While `wdtEnable` is 0 the counter is held at zero and no timeout occurs. After it returns to 1, a full 2^`WdtBits` period runs before the next timeout.
- R7: While `progMode` is 1 the counter is held at zero and no timeout occurs. After it returns to 0 with `wdtEnable` at 1, a full period runs before the next timeout.
- R8: `rdData` equals `VectorByte` when `addr` equals `ClearAddr` and 0x00 at any other address. A read has no effect on the watchdog.
- R9: `extRstReq` reaches `rstOut` through two clock flops. `rstOut` rises after the second edge that samples the request high and falls after the second edge that samples it low.
- R10: `rstOut` is high whenever the power-up hold, the watchdog pulse or the synchronized external request is active. The end of one source does not release reset while another is still active.
- R11: While `rstOut` is high the watchdog counter is held at zero, so a full period starts when reset releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all counters |
| powerOnN | input | 1 | Active-low power indication; asynchronously resets the whole block |
| extRstReq | input | 1 | External reset request, asynchronous, active high |
| wdtEnable | input | 1 | Watchdog enable option bit |
| progMode | input | 1 | Programming-voltage indication; suspends the watchdog |
| wrEn | input | 1 | Bus write strobe |
| addr | input | AddrW | Bus address |
| wrData | input | 8 | Bus write data |
| rdData | output | 8 | Bus read data |
| rstOut | output | 1 | Combined active-high reset |

## Verification
The watchdog clear and the watchdog timeout can land on the same clock edge. The bench provokes this by letting the counter run to its last value and issuing the clearing write on the cycle in which the timeout edge arrives. It judges the outcome by `rstOut` staying low after that edge and by the next timeout arriving one full period later. The random phase drives writes, enable and programming toggles and external requests against a cycle model, so clears and timeouts also coincide without being arranged.

// File: rtl/wdt_rst_pkg.sv
package wdt_rst_pkg;

  // status flags reported by the datapath to the control
  typedef struct packed {
    logic porDone;
    logic wdtAtMax;
    logic pulseBusy;
    logic extSync;
  } wdt_status_t;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic porStep;
    logic wdtClear;
    logic wdtStep;
    logic wdtTimeout;
    logic pulseStep;
  } wdt_strobe_t;

endpackage

// File: rtl/wdt_rst_dp.sv
module wdt_rst_dp
  import wdt_rst_pkg::*;
#(
  parameter int unsigned PorCycles  = 4064,
  parameter int unsigned WdtBits    = 18,
  parameter int unsigned PulseLen   = 16,
  parameter int unsigned SyncStages = 2,
  parameter int unsigned AddrW      = 13,
  parameter logic [AddrW-1:0] ClearAddr = 13'h1FF0,
  parameter logic [7:0] VectorByte = 8'h00
) (
  input  logic               clk,
  input  logic               powerOnN,
  input  logic               extRstReq,
  input  logic [AddrW-1:0]   addr,
  input  wdt_strobe_t        strb,
  output wdt_status_t        stat,
  output logic [WdtBits-1:0] wdtCount,
  output logic [7:0]         rdData
);

  localparam int unsigned PorW   = $clog2(PorCycles + 1);
  localparam int unsigned PulseW = $clog2(PulseLen + 1);
  localparam logic [PorW-1:0]   PorLast   = PorW'(PorCycles - 1);
  localparam logic [PulseW-1:0] PulseLoad = PulseW'(PulseLen);

  logic [PorW-1:0]       porCnt;
  logic                  porDone;
  logic [PulseW-1:0]     pulseCnt;
  logic [SyncStages-1:0] syncChain;

  // power-up hold counter
  always_ff @(posedge clk or negedge powerOnN) begin
    if (!powerOnN) begin
      porCnt  <= '0;
      porDone <= 1'b0;
    end else if (strb.porStep) begin
      porCnt <= porCnt + 1'b1;
      if (porCnt == PorLast) porDone <= 1'b1;
    end
  end

  // watchdog counter
  always_ff @(posedge clk or negedge powerOnN) begin
    if (!powerOnN) begin
      wdtCount <= '0;
    end else if (strb.wdtClear || strb.wdtTimeout) begin
      wdtCount <= '0;
    end else if (strb.wdtStep) begin
      wdtCount <= wdtCount + 1'b1;
    end
  end

  // timeout pulse length counter
  always_ff @(posedge clk or negedge powerOnN) begin
    if (!powerOnN) begin
      pulseCnt <= '0;
    end else if (strb.wdtTimeout) begin
      pulseCnt <= PulseLoad;
    end else if (strb.pulseStep) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  // external request synchronizer
  generate
    if (SyncStages == 1) begin : g_sync1
      always_ff @(posedge clk or negedge powerOnN) begin
        if (!powerOnN) syncChain <= '0;
        else           syncChain <= extRstReq;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge powerOnN) begin
        if (!powerOnN) syncChain <= '0;
        else           syncChain <= {syncChain[SyncStages-2:0], extRstReq};
      end
    end
  endgenerate

  always_comb begin
    stat.porDone   = porDone;
    stat.wdtAtMax  = &wdtCount;
    stat.pulseBusy = (pulseCnt != '0);
    stat.extSync   = syncChain[SyncStages-1];
  end

  // read path: the clear address returns the stored vector byte
  assign rdData = (addr == ClearAddr) ? VectorByte : 8'h00;

endmodule

// File: rtl/wdt_rst_ctrl.sv
module wdt_rst_ctrl
  import wdt_rst_pkg::*;
#(
  parameter int unsigned AddrW = 13,
  parameter logic [AddrW-1:0] ClearAddr = 13'h1FF0
) (
  input  logic             wrEn,
  input  logic [AddrW-1:0] addr,
  input  logic             clearBit,
  input  logic             wdtEnable,
  input  logic             progMode,
  input  wdt_status_t      stat,
  output wdt_strobe_t      strb,
  output logic             rstOut
);

  logic serviceHit;
  logic wdtRun;

  always_comb begin
    serviceHit = wrEn && (addr == ClearAddr) && !clearBit;
    rstOut     = !stat.porDone || stat.pulseBusy || stat.extSync;
    wdtRun     = wdtEnable && !progMode && !rstOut;

    strb.porStep    = !stat.porDone;
    strb.wdtTimeout = wdtRun && stat.wdtAtMax && !serviceHit;
    strb.wdtClear   = !wdtRun || serviceHit;
    strb.wdtStep    = wdtRun && !serviceHit && !stat.wdtAtMax;
    strb.pulseStep  = stat.pulseBusy;
  end

endmodule

// File: rtl/wdt_rst_seq.sv
module wdt_rst_seq
  import wdt_rst_pkg::*;
#(
  parameter int unsigned PorCycles = 4064,
  parameter int unsigned WdtBits   = 18,
  parameter int unsigned PulseLen  = 16,
  parameter int unsigned AddrW     = 13,
  parameter logic [AddrW-1:0] ClearAddr = 13'h1FF0,
  parameter logic [7:0] VectorByte = 8'h00
) (
  input  logic             clk,
  input  logic             powerOnN,
  input  logic             extRstReq,
  input  logic             wdtEnable,
  input  logic             progMode,
  input  logic             wrEn,
  input  logic [AddrW-1:0] addr,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  output logic             rstOut
);

  wdt_status_t        stat;
  wdt_strobe_t        strb;
  logic [WdtBits-1:0] wdtCount;
  logic               porDone;
  logic               pulseBusy;
  logic               extSync;

  wdt_rst_ctrl #(
    .AddrW(AddrW), .ClearAddr(ClearAddr)
  ) i_ctrl (
    .wrEn(wrEn), .addr(addr), .clearBit(wrData[0]),
    .wdtEnable(wdtEnable), .progMode(progMode),
    .stat(stat), .strb(strb), .rstOut(rstOut)
  );

  wdt_rst_dp #(
    .PorCycles(PorCycles), .WdtBits(WdtBits), .PulseLen(PulseLen),
    .SyncStages(2), .AddrW(AddrW), .ClearAddr(ClearAddr),
    .VectorByte(VectorByte)
  ) i_dp (
    .clk(clk), .powerOnN(powerOnN), .extRstReq(extRstReq),
    .addr(addr), .strb(strb), .stat(stat),
    .wdtCount(wdtCount), .rdData(rdData)
  );

  assign porDone   = stat.porDone;
  assign pulseBusy = stat.pulseBusy;
  assign extSync   = stat.extSync;

endmodule

// File: rtl/wdt_rst_seq_chk.sv
module wdt_rst_seq_chk #(
  parameter int unsigned WdtBits  = 18,
  parameter int unsigned PulseLen = 16,
  parameter int unsigned AddrW    = 13,
  parameter logic [AddrW-1:0] ClearAddr = 13'h1FF0,
  parameter logic [7:0] VectorByte = 8'h00
) (
  input logic               clk,
  input logic               powerOnN,
  input logic               wdtEnable,
  input logic               progMode,
  input logic               wrEn,
  input logic [AddrW-1:0]   addr,
  input logic [7:0]         wrData,
  input logic [7:0]         rdData,
  input logic               rstOut,
  input logic               porDone,
  input logic               pulseBusy,
  input logic               extSync,
  input logic [WdtBits-1:0] wdtCount
);

  int unsigned highRun;

  always_ff @(posedge clk or negedge powerOnN) begin
    if (!powerOnN)      highRun <= 0;
    else if (pulseBusy) highRun <= highRun + 1;
    else                highRun <= 0;
  end

  a_r1_por_hold: assert property (@(posedge clk) disable iff (!powerOnN)
    !porDone |-> rstOut);

  a_r3_pulse_len: assert property (@(posedge clk) disable iff (!powerOnN)
    $fell(pulseBusy) |-> (highRun == PulseLen));

  a_r4_clear_write: assert property (@(posedge clk) disable iff (!powerOnN)
    (wrEn && addr == ClearAddr && (wrData | 8'hFE) == 8'hFE) |=> (wdtCount == '0));

  a_r6_disabled_zero: assert property (@(posedge clk) disable iff (!powerOnN)
    !wdtEnable |=> (wdtCount == '0));

  a_r7_prog_no_fire: assert property (@(posedge clk) disable iff (!powerOnN)
    progMode |=> !$rose(pulseBusy));

  a_r8_vector_read: assert property (@(posedge clk) disable iff (!powerOnN)
    (addr == ClearAddr) |-> (rdData == VectorByte));

  a_r10_sources_hold: assert property (@(posedge clk) disable iff (!powerOnN)
    (extSync || pulseBusy) |-> rstOut);

  a_r11_held_in_reset: assert property (@(posedge clk) disable iff (!powerOnN)
    rstOut |=> (wdtCount == '0));

endmodule

bind wdt_rst_seq wdt_rst_seq_chk #(
  .WdtBits(WdtBits), .PulseLen(PulseLen), .AddrW(AddrW),
  .ClearAddr(ClearAddr), .VectorByte(VectorByte)
) i_chk (.*);

// File: tb/test_wdt_rst_seq.sv
module test_wdt_rst_seq;

  localparam int ClkPeriod = 10;
  localparam int P = 40;
  localparam int N = 6;
  localparam int T = 1 << N;
  localparam int L = 5;
  localparam int AW = 13;
  localparam logic [AW-1:0] ClrA = 13'h1FF0;
  localparam logic [7:0] Vec = 8'h5A;

  logic clk = 1'b0;
  logic powerOnN, extRstReq, wdtEnable, progMode, wrEn;
  logic [AW-1:0] addr;
  logic [7:0] wrData, rdData;
  logic rstOut;

  int total = 0;
  int bad = 0;

  // reference model state
  int mPorCnt, mWdt, mPulse;
  bit mPorDone, mS1, mS2;

  wdt_rst_seq #(
    .PorCycles(P), .WdtBits(N), .PulseLen(L), .AddrW(AW),
    .ClearAddr(ClrA), .VectorByte(Vec)
  ) i_wdt_rst_seq (
    .clk(clk), .powerOnN(powerOnN), .extRstReq(extRstReq),
    .wdtEnable(wdtEnable), .progMode(progMode), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rstOut(rstOut)
  );

  always #(ClkPeriod / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic bit mRst();
    return !mPorDone || (mPulse != 0) || mS2;
  endfunction

  function automatic int expRd(input logic [AW-1:0] a);
    return (a == ClrA) ? int'(Vec) : 0;
  endfunction

  task automatic modelReset();
    mPorCnt = 0; mPorDone = 0; mWdt = 0; mPulse = 0; mS1 = 0; mS2 = 0;
  endtask

  task automatic modelEdge();
    bit rst, svc, run, fire;
    rst  = mRst();
    svc  = wrEn && (addr == ClrA) && !wrData[0];
    run  = wdtEnable && !progMode && !rst;
    fire = run && (mWdt == T - 1) && !svc;
    if (!mPorDone) begin
      if (mPorCnt == P - 1) mPorDone = 1;
      mPorCnt++;
    end
    mPulse = fire ? L : ((mPulse != 0) ? mPulse - 1 : 0);
    mWdt   = (!run || svc || fire) ? 0 : mWdt + 1;
    mS2 = mS1;
    mS1 = extRstReq;
  endtask

  // one clock: model follows the edge, outputs sampled at the falling edge
  task automatic stepCycle();
    @(posedge clk);
    if (powerOnN) modelEdge();
    @(negedge clk);
    check(rstOut == mRst(), "R10 model rstOut", int'(rstOut), int'(mRst()));
    check(int'(rdData) == expRd(addr), "R8 rdData", int'(rdData), expRd(addr));
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    stepCycle();
    wrEn = 1'b0; addr = 13'h0100; wrData = 8'h00;
  endtask

  task automatic waitLevel(input logic lvl, input int limit, output int n);
    n = 0;
    while (rstOut !== lvl && n < limit) begin
      stepCycle();
      n++;
    end
  endtask

  initial begin
    #(ClkPeriod * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishRun();
  end

  initial begin
    int n;
    int allHigh;
    void'($urandom(32'd7319));
    powerOnN = 1'b0; extRstReq = 1'b0; wdtEnable = 1'b1; progMode = 1'b0;
    wrEn = 1'b0; addr = ClrA; wrData = 8'h00;
    modelReset();
    repeat (3) @(negedge clk);
    check(rstOut == 1'b1, "R1 reset state", int'(rstOut), 1);
    check(rdData == Vec, "R8 vector read", int'(rdData), int'(Vec));
    addr = 13'h1FF1;
    #1 check(rdData == 8'h00, "R8 other addr read", int'(rdData), 0);
    addr = 13'h0100;

    // R1 power-up hold length
    powerOnN = 1'b1;
    waitLevel(1'b0, 5000, n);
    check(n == P, "R1 hold length", n, P);

    // R2 / R3 timeout and pulse
    waitLevel(1'b1, 5000, n);
    check(n == T, "R2 timeout period", n, T);
    waitLevel(1'b0, 100, n);
    check(n == L, "R3 pulse length", n, L);

    // R5 ignored writes, reads at the clear address in between
    n = 0;
    while (!rstOut && n < 3 * T) begin
      if (n % 4 == 1)      busWrite(ClrA, 8'(($urandom % 128) * 2 + 1));
      else if (n % 7 == 3) busWrite(13'h1FF2, 8'h00);
      else begin addr = ClrA; stepCycle(); addr = 13'h0100; end
      n++;
    end
    check(n == T, "R5 ignored writes keep period", n, T);
    waitLevel(1'b0, 100, n);

    // R4 clear on the edge that would time out
    repeat (T - 1) stepCycle();
    busWrite(ClrA, 8'hFE);
    check(rstOut == 1'b0, "R4 clear beats timeout", int'(rstOut), 0);
    waitLevel(1'b1, 5000, n);
    check(n == T, "R4 period after clear", n, T);
    waitLevel(1'b0, 100, n);

    // R6 enable off then on
    repeat (20) stepCycle();
    wdtEnable = 1'b0;
    repeat (3 * T) stepCycle();
    check(rstOut == 1'b0, "R6 disabled no timeout", int'(rstOut), 0);
    wdtEnable = 1'b1;
    waitLevel(1'b1, 5000, n);
    check(n == T, "R6 full period after enable", n, T);
    waitLevel(1'b0, 100, n);

    // R7 programming mode
    repeat (30) stepCycle();
    progMode = 1'b1;
    repeat (3 * T) stepCycle();
    check(rstOut == 1'b0, "R7 prog mode no timeout", int'(rstOut), 0);
    progMode = 1'b0;
    waitLevel(1'b1, 5000, n);
    check(n == T, "R7 full period after prog", n, T);
    waitLevel(1'b0, 100, n);

    // R9 synchronizer latency, R11 counter held during reset
    repeat (25) stepCycle();
    extRstReq = 1'b1;
    stepCycle();
    check(rstOut == 1'b0, "R9 one edge later", int'(rstOut), 0);
    stepCycle();
    check(rstOut == 1'b1, "R9 two edges later", int'(rstOut), 1);
    repeat (20) stepCycle();
    extRstReq = 1'b0;
    stepCycle();
    check(rstOut == 1'b1, "R9 release one edge", int'(rstOut), 1);
    stepCycle();
    check(rstOut == 1'b0, "R9 release two edges", int'(rstOut), 0);
    waitLevel(1'b1, 5000, n);
    check(n == T, "R11 full period after reset", n, T);

    // R10 pulse stretched by external request
    extRstReq = 1'b1;
    allHigh = 1;
    repeat (L + 10) begin stepCycle(); if (!rstOut) allHigh = 0; end
    check(allHigh == 1, "R10 pulse stretched", allHigh, 1);
    extRstReq = 1'b0;
    waitLevel(1'b0, 100, n);
    check(n == 2, "R10 release after request", n, 2);

    // R10 power-up hold stretched by external request
    powerOnN = 1'b0; extRstReq = 1'b1;
    modelReset();
    repeat (2) @(negedge clk);
    powerOnN = 1'b1;
    allHigh = 1;
    repeat (P + 20) begin stepCycle(); if (!rstOut) allHigh = 0; end
    check(allHigh == 1, "R10 hold stretched", allHigh, 1);
    extRstReq = 1'b0;
    waitLevel(1'b0, 100, n);
    check(n == 2, "R10 release after hold", n, 2);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      wrEn   = ($urandom % 40) == 0;
      addr   = ($urandom % 3 != 0) ? ClrA : AW'($urandom);
      wrData = 8'($urandom);
      if ($urandom % 200 == 0) wdtEnable = ~wdtEnable;
      if ($urandom % 300 == 0) progMode = ~progMode;
      if (extRstReq) extRstReq = ($urandom % 8) != 0;
      else           extRstReq = ($urandom % 400) == 0;
      stepCycle();
    end

    finishRun();
  end

endmodule